// File: doc/BRIEF.md
# Event-Priority State Updater

This block keeps a small state value for a timer and changes it when events fire. Each clock cycle it sees one fired flag per event. Each event also carries a state operand and a mode bit. If any events fire, the block picks the one with the highest index. It then either replaces the state with that event's operand or adds the operand to the state.

The result appears on the clock edge that follows the cycle in which the events were seen. If no event fires, the state keeps its value. A registered debug pair reports which event won the most recent update, and whether there was a winner at all. The logic that makes the events, and the logic that uses the state to qualify them, sits outside this block.

Top module: `event_state_updater`

## Requirements
- R1: While reset is asserted, and after it, the state reads 0, the winner-valid flag reads 0 and the winner index reads 0.
- R2: In a cycle where no event fires, the state after the next edge equals the state before it, and the winner-valid flag reads 0.
- R3: When the winning event's mode bit is 1 (load), the state after the next edge equals that event's operand.
- R4: When the winning event's mode bit is 0 (add), the state after the next edge equals the old state plus the operand, modulo 32. Any carry is dropped.
- R5: When the winning event has mode bit 0 and operand 0, the state does not change.
- R6: When several events fire in the same cycle, only the highest-numbered one affects the state. The operands and mode bits of the lower events have no effect.
- R7: After an edge that follows a cycle with at least one fired event, the winner-valid flag reads 1 and the winner index equals the number of the highest fired event.
- R8: Event i's operand occupies bits [5*i+4 : 5*i] of the operand bus. Event i's mode bit is bit i of the mode bus. Event i's fired flag is bit i of the fire bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_fire | input | NUM_EVT | One fired flag per event |
| evt_operand | input | NUM_EVT*STATE_W | Per-event state operands, packed by index |
| evt_load | input | NUM_EVT | Per-event mode: 1 loads, 0 adds |
| state_q | output | STATE_W | Current state |
| win_valid | output | 1 | An event won the last update |
| win_idx | output | $clog2(NUM_EVT) | Index of the last winning event |

## Verification
The hardest case to reach from the ports is a cycle where many events fire together and the lower ones carry operands and modes that would give a different, visible result. One such case has a low event that loads while the highest one adds. The stimulus puts distinct operands on every fired event and checks that the state matches only the top event's arithmetic. It also covers sums that cross 31, where the dropped carry is the only evidence of correct behaviour.

// File: rtl/sru_pkg.sv
package sru_pkg;
  localparam int unsigned SRU_STATE_W = 5;

  typedef enum logic {
    SRU_MODE_ADD  = 1'b0,
    SRU_MODE_LOAD = 1'b1
  } sru_mode_e;
endpackage

// File: rtl/sru_prio_pick.sv
// Highest-index fired event wins.
module sru_prio_pick #(
  parameter int unsigned NUM_EVT = 16,
  localparam int unsigned IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
  input  logic [NUM_EVT-1:0] fire,
  output logic               any_fire,
  output logic [IDX_W-1:0]   pick_idx
);
  always_comb begin
    any_fire = 1'b0;
    pick_idx = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (fire[i]) begin
        any_fire = 1'b1;
        pick_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/sru_state_alu.sv
// Load or wrap-around add of an operand into the state.
module sru_state_alu
  import sru_pkg::*;
#(
  parameter int unsigned STATE_W = SRU_STATE_W
) (
  input  logic [STATE_W-1:0] cur_state,
  input  logic [STATE_W-1:0] operand,
  input  sru_mode_e          mode,
  output logic [STATE_W-1:0] new_state
);
  logic [STATE_W-1:0] sum;

  always_comb begin
    sum = cur_state + operand;
    unique case (mode)
      SRU_MODE_LOAD: new_state = operand;
      default:       new_state = sum;
    endcase
  end
endmodule

// File: rtl/event_state_updater.sv
module event_state_updater
  import sru_pkg::*;
#(
  parameter int unsigned NUM_EVT = 16,
  parameter int unsigned STATE_W = SRU_STATE_W,
  localparam int unsigned IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_EVT-1:0]         evt_fire,
  input  logic [NUM_EVT*STATE_W-1:0] evt_operand,
  input  logic [NUM_EVT-1:0]         evt_load,
  output logic [STATE_W-1:0]         state_q,
  output logic                       win_valid,
  output logic [IDX_W-1:0]           win_idx
);
  logic [STATE_W-1:0] opnd_arr [NUM_EVT];
  logic               any_fire;
  logic [IDX_W-1:0]   sel_idx;
  logic [STATE_W-1:0] sel_opnd;
  sru_mode_e          sel_mode;
  logic [STATE_W-1:0] alu_out;
  logic               state_en;
  logic [STATE_W-1:0] state_d;
  logic               valid_d;
  logic [IDX_W-1:0]   idx_d;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_unpack
    assign opnd_arr[g] = evt_operand[g*STATE_W +: STATE_W];
  end

  sru_prio_pick #(.NUM_EVT(NUM_EVT)) u_pick (
    .fire     (evt_fire),
    .any_fire (any_fire),
    .pick_idx (sel_idx)
  );

  assign sel_opnd = opnd_arr[sel_idx];
  assign sel_mode = sru_mode_e'(evt_load[sel_idx]);

  sru_state_alu #(.STATE_W(STATE_W)) u_alu (
    .cur_state (state_q),
    .operand   (sel_opnd),
    .mode      (sel_mode),
    .new_state (alu_out)
  );

  // next-state
  always_comb begin
    state_en = any_fire;
    state_d  = alu_out;
    valid_d  = any_fire;
    idx_d    = any_fire ? sel_idx : win_idx;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= '0;
      win_valid <= 1'b0;
      win_idx   <= '0;
    end else begin
      if (state_en) begin
        state_q <= state_d;
        win_idx <= idx_d;
      end
      win_valid <= valid_d;
    end
  end

  // R2: idle cycle holds the state and clears the valid flag
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(|evt_fire) |=> ($stable(state_q) && !win_valid));

  // R3: load by the winner
  a_r3_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    ((|evt_fire) && evt_load[sel_idx]) |=> (state_q == $past(sel_opnd)));

  // R4: wrapped add by the winner
  a_r4_wrap_add: assert property (@(posedge clk) disable iff (!rst_n)
    ((|evt_fire) && !evt_load[sel_idx]) |=>
      (state_q == STATE_W'($past(state_q) + $past(sel_opnd))));

  // R5: add of zero leaves state alone
  a_r5_zero_add: assert property (@(posedge clk) disable iff (!rst_n)
    ((|evt_fire) && !evt_load[sel_idx] && (sel_opnd == '0)) |=> $stable(state_q));

  // R6: the picked index is the top fired bit
  a_r6_top_pick: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_fire) |-> ((evt_fire >> sel_idx) == NUM_EVT'(1)));

  // R7: debug pair follows a fired cycle
  a_r7_debug_report: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_fire) |=> (win_valid && (win_idx == $past(sel_idx))));
endmodule

// File: tb/event_state_updater_tb.sv
module event_state_updater_tb;
  localparam int unsigned N  = 16;
  localparam int unsigned W  = 5;
  localparam int unsigned IW = $clog2(N);

  logic             clk;
  logic             rst_n;
  logic [N-1:0]     evt_fire;
  logic [N*W-1:0]   evt_operand;
  logic [N-1:0]     evt_load;
  logic [W-1:0]     state_q;
  logic             win_valid;
  logic [IW-1:0]    win_idx;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  event_state_updater #(.NUM_EVT(N), .STATE_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_fire(evt_fire), .evt_operand(evt_operand),
    .evt_load(evt_load), .state_q(state_q), .win_valid(win_valid), .win_idx(win_idx)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_inputs();
    evt_fire = '0; evt_operand = '0; evt_load = '0;
  endtask

  task automatic set_evt(input int i, input int opnd, input bit ld);
    evt_fire[i] = 1'b1;
    evt_operand[i*W +: W] = W'(opnd);
    evt_load[i] = ld;
  endtask

  // apply driven inputs for one edge, then sample on the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; clear_inputs();
    repeat (2) @(negedge clk);
    check("R1 state in reset", state_q, 0);
    check("R1 valid in reset", win_valid, 0);
    check("R1 idx in reset", win_idx, 0);
    rst_n = 1'b1;
    step();
    check("R1 state after release", state_q, 0);
  endtask

  task automatic t_load();
    set_evt(3, 7, 1'b1);
    step();
    check("R3 load 7", state_q, 7);
    check("R7 valid after load", win_valid, 1);
    check("R7 idx after load", win_idx, 3);
  endtask

  task automatic t_add_wrap();
    set_evt(0, 30, 1'b0);
    step();
    check("R4 7+30 wraps", state_q, 5);
    set_evt(9, 31, 1'b0);
    step();
    check("R4 5+31 wraps", state_q, 4);
    check("R8 idx 9", win_idx, 9);
  endtask

  task automatic t_zero_add();
    set_evt(6, 0, 1'b0);
    step();
    check("R5 add zero keeps", state_q, 4);
    check("R7 valid on zero add", win_valid, 1);
  endtask

  task automatic t_idle();
    step();
    check("R2 idle keeps state", state_q, 4);
    check("R2 idle clears valid", win_valid, 0);
    // operands and modes with no fire flag: still idle
    evt_operand = '1; evt_load = '1;
    step();
    check("R2 unfired operands ignored", state_q, 4);
  endtask

  task automatic t_multi();
    set_evt(2, 9, 1'b1);
    set_evt(5, 1, 1'b0);
    set_evt(15, 20, 1'b1);
    step();
    check("R6 top event 15 loads", state_q, 20);
    check("R7 idx 15", win_idx, 15);
    // low event loads, top adds: only add applies
    set_evt(1, 2, 1'b1);
    set_evt(14, 3, 1'b0);
    step();
    check("R6 low load ignored", state_q, 23);
    check("R7 idx 14", win_idx, 14);
    // low adds, top is zero add: no change
    set_evt(0, 11, 1'b0);
    set_evt(8, 0, 1'b0);
    step();
    check("R6 R5 top zero add wins", state_q, 23);
    check("R8 idx 8", win_idx, 8);
  endtask

  task automatic t_load_zero_then_reset();
    set_evt(12, 0, 1'b1);
    step();
    check("R3 load zero", state_q, 0);
    set_evt(4, 17, 1'b1);
    step();
    check("R3 load 17", state_q, 17);
    #1 rst_n = 1'b0;
    #1;
    check("R1 async clear state", state_q, 0);
    check("R1 async clear valid", win_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    clear_inputs();
    rst_n = 1'b0;
    t_reset();
    t_load();
    t_add_wrap();
    t_zero_add();
    t_idle();
    t_multi();
    t_load_zero_then_reset();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule